// File: doc/BRIEF.md
# FIFO Interrupt Generation Unit

This block holds the transmit and receive data queues of a serial peripheral controller and produces the interrupt lines that tell the host when to service them. The host bus side reaches everything through one small register window. A write to the data register queues a word for transmission, and a read of the same register takes the oldest received word. The serial engine side takes transmit words and delivers received words through single-cycle pop and push strobes.

Five interrupt sources are produced. Two are level sources that follow the queue fill levels and clear themselves: transmit running low and receive running high. Three are sticky error sources: transmit overflow, receive overflow and receive underflow. Each error source clears only when the host reads its own clear register. A mask register gates each source onto its own output pin. A combined output is the OR of the five gated sources.

Top module: `spi_fifo_irq_unit`

Register window (`host_addr`): 0 data, 1 transmit threshold, 2 receive threshold, 3 mask, 4 raw status, 5 masked status, 6 transmit-overflow clear, 7 receive-overflow clear, 8 receive-underflow clear, 9 transmit count, 10 receive count. The source bit order is the same in the mask and in both status registers: bit 0 transmit low, bit 1 transmit overflow, bit 2 receive high, bit 3 receive overflow, bit 4 receive underflow. `host_rdata` is zero whenever `host_rd` is low.

## Requirements
- R1: After reset both queues are empty (addresses 9 and 10 read 0), all three error flags are clear, the mask (address 3) reads 5'h1F, and both thresholds (addresses 1 and 2) read 0.
- R2: The transmit-low source (bit 0) is high exactly when the transmit count is less than or equal to the 4-bit transmit threshold at address 1.
- R3: A data write while the transmit queue holds 16 words is dropped and sets the transmit-overflow flag (bit 1). The flag stays set until the host reads address 6, and that read returns the flag in bit 0.
- R4: The receive-high source (bit 2) is high exactly when the receive count is greater than or equal to the receive threshold at address 2 plus one.
- R5: A serial push while the receive queue holds 16 words drops the word and sets the receive-overflow flag (bit 3). The flag stays set until the host reads address 7.
- R6: A data read of an empty receive queue returns 32'h0, leaves the queue unchanged and sets the receive-underflow flag (bit 4). The flag stays set until the host reads address 8.
- R7: Each output pin equals its raw source ANDed with its mask bit at address 3. Address 4 shows the raw sources and address 5 shows the masked ones.
- R8: `irq_any` is the OR of the five masked sources, so it is low whenever all five mask bits are 0.
- R9: When a new error event and the read of that flag's clear register happen in the same cycle, the flag is set after the edge.
- R10: Each queue delivers words in the order they were accepted. Dropped words never appear.
- R11: Writes to addresses 4 and 5 have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (reads with side effects act at the edge) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle `host_rd` is high |
| ser_tx_pop | input | 1 | Serial side takes the head transmit word |
| ser_tx_data | output | 32 | Head of the transmit queue |
| ser_tx_valid | output | 1 | Transmit queue holds at least one word |
| ser_rx_push | input | 1 | Serial side delivers a received word |
| ser_rx_data | input | 32 | Received word |
| irq_tx_low | output | 1 | Masked transmit-low interrupt |
| irq_tx_ovf | output | 1 | Masked transmit-overflow interrupt |
| irq_rx_high | output | 1 | Masked receive-high interrupt |
| irq_rx_ovf | output | 1 | Masked receive-overflow interrupt |
| irq_rx_unf | output | 1 | Masked receive-underflow interrupt |
| irq_any | output | 1 | OR of the masked interrupts |

## Verification
The assertions check the following on every cycle: the mask gating and the combined OR, the dropping of overflow words as seen in the counts, setting and holding of each sticky flag, the zero data returned on underflow, the rule that a new event wins over a clear read, and the bounds on the counts. Only the bench scenarios can show the threshold boundaries at specific fill levels, the word order through each queue, the reset values, and the read-only status registers. A behavioural queue model compares against every output on every clock.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int unsigned N_SRC = 5;

    localparam int unsigned SRC_TX_LOW  = 0;
    localparam int unsigned SRC_TX_OVF  = 1;
    localparam int unsigned SRC_RX_HIGH = 2;
    localparam int unsigned SRC_RX_OVF  = 3;
    localparam int unsigned SRC_RX_UNF  = 4;

    localparam int unsigned N_ERR   = 3;
    localparam int unsigned ERR_TXO = 0;
    localparam int unsigned ERR_RXO = 1;
    localparam int unsigned ERR_RXU = 2;

    typedef enum logic [3:0] {
        REG_DATA      = 4'd0,
        REG_TX_THR    = 4'd1,
        REG_RX_THR    = 4'd2,
        REG_MASK      = 4'd3,
        REG_RAW       = 4'd4,
        REG_MSK_STAT  = 4'd5,
        REG_CLR_TXOVF = 4'd6,
        REG_CLR_RXOVF = 4'd7,
        REG_CLR_RXUNF = 4'd8,
        REG_TX_CNT    = 4'd9,
        REG_RX_CNT    = 4'd10
    } reg_addr_e;

endpackage

// File: rtl/spi_irq_fifo.sv
module spi_irq_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
        end
    end

endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate #(
    parameter int unsigned N = 5
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] mask,
    output logic [N-1:0] pins,
    output logic         any
);

    assign pins = raw & mask;
    assign any  = |pins;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    output logic              ser_tx_valid,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    output logic              irq_tx_low,
    output logic              irq_tx_ovf,
    output logic              irq_rx_high,
    output logic              irq_rx_ovf,
    output logic              irq_rx_unf,
    output logic              irq_any
);

    localparam int unsigned THR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    reg_addr_e          addr;
    logic               wr_data;
    logic               rd_data;
    logic [THR_W-1:0]   tx_thr_q;
    logic [THR_W-1:0]   rx_thr_q;
    logic [N_SRC-1:0]   mask_q;

    logic [CNT_W-1:0]   tx_cnt;
    logic [CNT_W-1:0]   rx_cnt;
    logic               tx_full;
    logic               tx_empty;
    logic               rx_full;
    logic               rx_empty;
    logic [DATA_W-1:0]  rx_head;

    logic [N_ERR-1:0]   err_set;
    logic [N_ERR-1:0]   err_clr;
    logic [N_ERR-1:0]   err_flag;

    logic               tx_low;
    logic               rx_high;
    logic [N_SRC-1:0]   raw_vec;
    logic [N_SRC-1:0]   pin_vec;

    assign addr    = reg_addr_e'(host_addr);
    assign wr_data = host_wr && (addr == REG_DATA);
    assign rd_data = host_rd && (addr == REG_DATA);

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            mask_q   <= '1;
        end else if (host_wr) begin
            unique case (addr)
                REG_TX_THR: tx_thr_q <= host_wdata[THR_W-1:0];
                REG_RX_THR: rx_thr_q <= host_wdata[THR_W-1:0];
                REG_MASK:   mask_q   <= host_wdata[N_SRC-1:0];
                default:    ;
            endcase
        end
    end

    // Transmit queue: host fills, serial side drains
    spi_irq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_data),
        .push_data (host_wdata),
        .pop       (ser_tx_pop),
        .head      (ser_tx_data),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    // Receive queue: serial side fills, host drains
    spi_irq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (rd_data),
        .head      (rx_head),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign ser_tx_valid = !tx_empty;

    // Error events and their clear-on-read registers
    assign err_set[ERR_TXO] = wr_data && tx_full;
    assign err_set[ERR_RXO] = ser_rx_push && rx_full;
    assign err_set[ERR_RXU] = rd_data && rx_empty;

    assign err_clr[ERR_TXO] = host_rd && (addr == REG_CLR_TXOVF);
    assign err_clr[ERR_RXO] = host_rd && (addr == REG_CLR_RXOVF);
    assign err_clr[ERR_RXU] = host_rd && (addr == REG_CLR_RXUNF);

    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        spi_irq_sticky u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (err_set[g]),
            .clr   (err_clr[g]),
            .flag  (err_flag[g])
        );
    end

    // Level sources: low mark inclusive, high mark one above threshold
    assign tx_low  = (tx_cnt <= CNT_W'(tx_thr_q));
    assign rx_high = (rx_cnt >= (CNT_W'(rx_thr_q) + CNT_W'(1)));

    always_comb begin
        raw_vec              = '0;
        raw_vec[SRC_TX_LOW]  = tx_low;
        raw_vec[SRC_TX_OVF]  = err_flag[ERR_TXO];
        raw_vec[SRC_RX_HIGH] = rx_high;
        raw_vec[SRC_RX_OVF]  = err_flag[ERR_RXO];
        raw_vec[SRC_RX_UNF]  = err_flag[ERR_RXU];
    end

    spi_irq_gate #(.N(N_SRC)) u_gate (
        .raw  (raw_vec),
        .mask (mask_q),
        .pins (pin_vec),
        .any  (irq_any)
    );

    assign irq_tx_low  = pin_vec[SRC_TX_LOW];
    assign irq_tx_ovf  = pin_vec[SRC_TX_OVF];
    assign irq_rx_high = pin_vec[SRC_RX_HIGH];
    assign irq_rx_ovf  = pin_vec[SRC_RX_OVF];
    assign irq_rx_unf  = pin_vec[SRC_RX_UNF];

    // Host read path
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (addr)
                REG_DATA:      host_rdata = rx_empty ? '0 : rx_head;
                REG_TX_THR:    host_rdata = DATA_W'(tx_thr_q);
                REG_RX_THR:    host_rdata = DATA_W'(rx_thr_q);
                REG_MASK:      host_rdata = DATA_W'(mask_q);
                REG_RAW:       host_rdata = DATA_W'(raw_vec);
                REG_MSK_STAT:  host_rdata = DATA_W'(pin_vec);
                REG_CLR_TXOVF: host_rdata = DATA_W'(err_flag[ERR_TXO]);
                REG_CLR_RXOVF: host_rdata = DATA_W'(err_flag[ERR_RXO]);
                REG_CLR_RXUNF: host_rdata = DATA_W'(err_flag[ERR_RXU]);
                REG_TX_CNT:    host_rdata = DATA_W'(tx_cnt);
                REG_RX_CNT:    host_rdata = DATA_W'(rx_cnt);
                default:       host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              ser_tx_pop,
    input logic              ser_rx_push,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [4:0]        raw_vec,
    input logic [4:0]        mask_q,
    input logic [4:0]        irq_vec,
    input logic              irq_any
);

    logic wr_dat, rd_dat, tx_is_full, rx_is_full, rx_is_empty;
    assign wr_dat      = host_wr && (host_addr == 4'd0);
    assign rd_dat      = host_rd && (host_addr == 4'd0);
    assign tx_is_full  = (tx_cnt == CNT_W'(DEPTH));
    assign rx_is_full  = (rx_cnt == CNT_W'(DEPTH));
    assign rx_is_empty = (rx_cnt == '0);

    assert_pin_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & ~mask_q) == 5'b0);

    assert_any_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (irq_vec != 5'b0));

    assert_tx_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && tx_is_full && !ser_tx_pop) |=> (tx_cnt == CNT_W'(DEPTH)));

    assert_tx_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && tx_is_full) |=> raw_vec[1]);

    assert_tx_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec[1] && !(host_rd && host_addr == 4'd6)) |=> raw_vec[1]);

    assert_tx_ovf_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 4'd6 && !(wr_dat && tx_is_full)) |=> !raw_vec[1]);

    assert_rx_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_is_full && !rd_dat) |=> (rx_cnt == CNT_W'(DEPTH)) && raw_vec[3]);

    assert_rx_ovf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec[3] && !(host_rd && host_addr == 4'd7)) |=> raw_vec[3]);

    assert_unf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_is_empty) |-> (host_rdata == '0));

    assert_unf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dat && rx_is_empty && !ser_rx_push) |=> raw_vec[4] && (rx_cnt == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_is_full && host_rd && host_addr == 4'd7) |=> raw_vec[3]);

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .ser_tx_pop  (ser_tx_pop),
    .ser_rx_push (ser_rx_push),
    .tx_cnt      (tx_cnt),
    .rx_cnt      (rx_cnt),
    .raw_vec     (raw_vec),
    .mask_q      (mask_q),
    .irq_vec     ({irq_rx_unf, irq_rx_ovf, irq_rx_high, irq_tx_ovf, irq_tx_low}),
    .irq_any     (irq_any)
);

// File: tb/spi_fifo_irq_unit_tb.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  host_addr;
    logic        host_wr;
    logic        host_rd;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        ser_tx_pop;
    logic [31:0] ser_tx_data;
    logic        ser_tx_valid;
    logic        ser_rx_push;
    logic [31:0] ser_rx_data;
    logic        irq_tx_low, irq_tx_ovf, irq_rx_high, irq_rx_ovf, irq_rx_unf, irq_any;

    always #2.5 clk = ~clk;

    spi_fifo_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .irq_tx_low(irq_tx_low), .irq_tx_ovf(irq_tx_ovf), .irq_rx_high(irq_rx_high),
        .irq_rx_ovf(irq_rx_ovf), .irq_rx_unf(irq_rx_unf), .irq_any(irq_any)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Behavioural reference model
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    int          m_txthr = 0;
    int          m_rxthr = 0;
    logic [4:0]  m_mask  = 5'h1F;
    bit          m_txovf = 0, m_rxovf = 0, m_rxunf = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] m_raw();
        logic [4:0] r;
        r[0] = (txq.size() <= m_txthr);
        r[1] = m_txovf;
        r[2] = (rxq.size() >= m_rxthr + 1);
        r[3] = m_rxovf;
        r[4] = m_rxunf;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:    return (rxq.size() > 0) ? rxq[0] : 32'h0;
            4'd1:    return 32'(m_txthr);
            4'd2:    return 32'(m_rxthr);
            4'd3:    return 32'(m_mask);
            4'd4:    return 32'(m_raw());
            4'd5:    return 32'(m_raw() & m_mask);
            4'd6:    return 32'(m_txovf);
            4'd7:    return 32'(m_rxovf);
            4'd8:    return 32'(m_rxunf);
            4'd9:    return 32'(txq.size());
            4'd10:   return 32'(rxq.size());
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_update();
        bit tx_wr, tx_pop_ok, tx_push_ok, rx_rd, rx_push_ok, rx_pop_ok;
        bit s_txo, s_rxo, s_rxu, c_txo, c_rxo, c_rxu;
        tx_wr      = host_wr && host_addr == 4'd0;
        tx_pop_ok  = ser_tx_pop && txq.size() > 0;
        tx_push_ok = tx_wr && txq.size() < 16;
        s_txo      = tx_wr && txq.size() == 16;
        rx_rd      = host_rd && host_addr == 4'd0;
        rx_push_ok = ser_rx_push && rxq.size() < 16;
        rx_pop_ok  = rx_rd && rxq.size() > 0;
        s_rxo      = ser_rx_push && rxq.size() == 16;
        s_rxu      = rx_rd && rxq.size() == 0;
        c_txo      = host_rd && host_addr == 4'd6;
        c_rxo      = host_rd && host_addr == 4'd7;
        c_rxu      = host_rd && host_addr == 4'd8;
        if (tx_pop_ok)  void'(txq.pop_front());
        if (tx_push_ok) txq.push_back(host_wdata);
        if (rx_pop_ok)  void'(rxq.pop_front());
        if (rx_push_ok) rxq.push_back(ser_rx_data);
        m_txovf = s_txo || (m_txovf && !c_txo);
        m_rxovf = s_rxo || (m_rxovf && !c_rxo);
        m_rxunf = s_rxu || (m_rxunf && !c_rxu);
        if (host_wr && host_addr == 4'd1) m_txthr = int'(host_wdata[3:0]);
        if (host_wr && host_addr == 4'd2) m_rxthr = int'(host_wdata[3:0]);
        if (host_wr && host_addr == 4'd3) m_mask  = host_wdata[4:0];
    endtask

    // One clock: compare every output against the model, then advance both
    task automatic step(input string tag);
        logic [4:0] exp_pins;
        #1;
        exp_pins = m_raw() & m_mask;
        chk(tag, "irq pins", 32'({irq_rx_unf, irq_rx_ovf, irq_rx_high, irq_tx_ovf, irq_tx_low}), 32'(exp_pins));
        chk(tag, "irq_any", 32'(irq_any), 32'(|exp_pins));
        chk(tag, "ser_tx_valid", 32'(ser_tx_valid), 32'(txq.size() > 0));
        if (txq.size() > 0) chk(tag, "ser_tx_data", ser_tx_data, txq[0]);
        if (host_rd) chk(tag, "host_rdata", host_rdata, m_read(host_addr));
        @(posedge clk);
        m_update();
        @(negedge clk);
        host_wr = 0; host_rd = 0; ser_tx_pop = 0; ser_rx_push = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input string tag);
        host_addr = 4'(a); host_wdata = d; host_wr = 1;
        step(tag);
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        host_addr = 4'(a); host_rd = 1;
        #1;
        v = host_rdata;
        step(tag);
        chk(tag, "register read", v, exp);
    endtask

    task automatic push(input logic [31:0] d, input string tag);
        ser_rx_push = 1; ser_rx_data = d;
        step(tag);
    endtask

    task automatic pop_chk(input logic [31:0] exp, input string tag);
        #1;
        chk(tag, "tx head order", ser_tx_data, exp);
        ser_tx_pop = 1;
        step(tag);
    endtask

    initial begin
        rst_n = 0; host_addr = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
        ser_tx_pop = 0; ser_rx_push = 0; ser_rx_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd_chk(9, 0, "R1");
        rd_chk(10, 0, "R1");
        rd_chk(1, 0, "R1");
        rd_chk(2, 0, "R1");
        rd_chk(3, 32'h1F, "R1");
        rd_chk(4, 32'h01, "R1");
        rd_chk(6, 0, "R1");
        rd_chk(7, 0, "R1");
        rd_chk(8, 0, "R1");

        // R2: transmit-low boundary at threshold 3
        wr(1, 3, "R2");
        for (int i = 0; i < 3; i++) wr(0, 32'hA0 + i, "R2");
        chk("R2", "irq_tx_low at count 3", 32'(irq_tx_low), 1);
        wr(0, 32'hA3, "R2");
        chk("R2", "irq_tx_low at count 4", 32'(irq_tx_low), 0);
        rd_chk(4, 32'h00, "R2");
        // R10: transmit order
        for (int i = 0; i < 4; i++) pop_chk(32'hA0 + i, "R10");
        chk("R2", "irq_tx_low after drain", 32'(irq_tx_low), 1);

        // R3: transmit overflow
        for (int i = 0; i < 16; i++) wr(0, 32'h100 + i, "R3");
        rd_chk(9, 16, "R3");
        wr(0, 32'hDEAD, "R3");
        rd_chk(9, 16, "R3");
        chk("R3", "irq_tx_ovf set", 32'(irq_tx_ovf), 1);
        repeat (3) step("R3");
        chk("R3", "irq_tx_ovf held", 32'(irq_tx_ovf), 1);
        rd_chk(6, 1, "R3");
        chk("R3", "irq_tx_ovf cleared", 32'(irq_tx_ovf), 0);
        for (int i = 0; i < 16; i++) pop_chk(32'h100 + i, "R10");
        chk("R10", "dropped word absent", 32'(ser_tx_valid), 0);

        // R11: status registers are read-only
        wr(4, 32'hFFFF_FFFF, "R11");
        wr(5, 32'hFFFF_FFFF, "R11");
        rd_chk(4, 32'h01, "R11");
        rd_chk(5, 32'h01, "R11");
        rd_chk(3, 32'h1F, "R11");

        // R4: receive-high boundary at threshold 2 (asserts at 3)
        wr(2, 2, "R4");
        push(32'hB0, "R4");
        push(32'hB1, "R4");
        chk("R4", "irq_rx_high at count 2", 32'(irq_rx_high), 0);
        push(32'hB2, "R4");
        chk("R4", "irq_rx_high at count 3", 32'(irq_rx_high), 1);
        rd_chk(0, 32'hB0, "R10");
        chk("R4", "irq_rx_high after read", 32'(irq_rx_high), 0);
        rd_chk(0, 32'hB1, "R10");
        rd_chk(0, 32'hB2, "R10");

        // R6: underflow
        rd_chk(0, 32'h0, "R6");
        chk("R6", "irq_rx_unf set", 32'(irq_rx_unf), 1);
        rd_chk(10, 0, "R6");
        push(32'hC5, "R6");
        rd_chk(0, 32'hC5, "R6");
        rd_chk(8, 1, "R6");
        chk("R6", "irq_rx_unf cleared", 32'(irq_rx_unf), 0);

        // R5: receive overflow
        for (int i = 0; i < 16; i++) push(32'h200 + i, "R5");
        push(32'hBAD, "R5");
        chk("R5", "irq_rx_ovf set", 32'(irq_rx_ovf), 1);
        rd_chk(10, 16, "R5");
        repeat (2) step("R5");
        chk("R5", "irq_rx_ovf held", 32'(irq_rx_ovf), 1);

        // R9: new event and clear read in the same cycle
        ser_rx_push = 1; ser_rx_data = 32'hBAD2; host_rd = 1; host_addr = 4'd7;
        step("R9");
        chk("R9", "irq_rx_ovf after set+clear", 32'(irq_rx_ovf), 1);
        rd_chk(7, 1, "R5");
        chk("R5", "irq_rx_ovf cleared", 32'(irq_rx_ovf), 0);
        for (int i = 0; i < 16; i++) rd_chk(0, 32'h200 + i, "R10");
        rd_chk(10, 0, "R10");

        // R7 / R8: masking
        rd_chk(0, 32'h0, "R7");
        wr(3, 32'h01, "R7");
        chk("R7", "irq_tx_low unmasked", 32'(irq_tx_low), 1);
        chk("R7", "irq_rx_unf masked", 32'(irq_rx_unf), 0);
        rd_chk(4, 32'h11, "R7");
        rd_chk(5, 32'h01, "R7");
        wr(3, 32'h00, "R8");
        chk("R8", "irq_any all masked", 32'(irq_any), 0);
        chk("R8", "pins all masked", 32'({irq_rx_unf, irq_rx_ovf, irq_rx_high, irq_tx_ovf, irq_tx_low}), 0);
        wr(3, 32'h10, "R8");
        chk("R8", "irq_any from underflow", 32'(irq_any), 1);
        chk("R7", "irq_tx_low masked", 32'(irq_tx_low), 0);
        wr(3, 32'h1F, "R7");
        rd_chk(8, 1, "R6");
        step("R8");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule